// File: doc/BRIEF.md
# Zero-suppressed pixel matrix readout with token passing

This block is a behavioural digital model of a square pixel matrix (16 columns by 16 rows by default) together with its readout periphery. It has two phases. While `detect` is high, each pixel watches its own single-bit hit input. The first hit sets a latch in that pixel, and the pixel's time-stamp register freezes on the value of a shared time-stamp counter. While `detect` is low, no new hits are recorded and the counter holds its value.

During readout, a pulse on `tok_start` places a token on the first pixel. The token then moves through the matrix one pixel per clock in row-major order. An empty pixel hands the token on straight away. A hit pixel keeps the token until the serializer can accept a frame. At that point it raises its column and row select lines. The periphery encodes those lines into a column address and a row address, and picks the pixel's stamp through its column's stamp buffer. The pixel then clears its hit latch and passes the token on.

Each frame leaves on a single serial line. Only hit pixels produce frames. When the token leaves the last pixel, a done flag is raised.

Top module: `pixmat_tokro`

## Requirements
- R1: While `rst_n` is low at a rising edge, every hit latch, stamp, the token and the time-stamp counter are cleared, and `sdo`, `frame_start` and `ro_done` are 0 from the following cycle.
- R2: The time-stamp counter is 5 bits wide and starts at 0 after reset. It increments by one (wrapping modulo 32) on each clock with `detect` high and holds while `detect` is low. A pixel's stamp equals the counter value in the cycle where its hit is sampled.
- R3: `hit_in` is ignored while `detect` is low: no latch is set and no frame results from it.
- R4: A pixel records at most one hit per detection phase. Later hits on the same pixel do not change its stamp and do not produce a second frame.
- R5: A rising edge with `tok_start` high places the token on pixel 0 and clears `ro_done`. The token then advances one pixel per clock while `detect` is low, and does not move while `detect` is high.
- R6: Pixels are visited in row-major order. Pixel index = row*16 + column, where `hit_in[index]` belongs to that pixel. Frames therefore leave in ascending index order.
- R7: A frame is 13 bits, sent most significant bit first: column[3:0], then row[3:0], then stamp[4:0], one bit per clock on `sdo`. `frame_start` is high only in the cycle that carries the first bit. `sdo` is 0 when no frame is being sent.
- R8: A hit pixel that holds the token waits while more than one bit of the current frame remains to be sent. Its frame starts in the cycle right after the previous frame's last bit. Its latch is cleared when the frame is taken, so each hit is reported once.
- R9: `ro_done` rises in the cycle after the token leaves the last pixel and stays high until the next `tok_start`. With no hits, it rises exactly 256 clocks after the `tok_start` edge, and no frames are sent.
- R10: A reset in the middle of a detection phase discards all recorded hits, so the following readout sends no frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for detection and readout |
| rst_n | input | 1 | Synchronous master reset, active low |
| detect | input | 1 | 1 = detection phase, 0 = readout phase |
| tok_start | input | 1 | Token reset: puts the token on pixel 0 |
| hit_in | input | 256 | Per-pixel discriminator outputs, index row*16+column |
| sdo | output | 1 | Serial frame data |
| frame_start | output | 1 | High with the first bit of each frame |
| ro_done | output | 1 | Token has left the last pixel |

## Verification
A hit sampled at a clock edge shows up only as a stamp inside a later frame. A frame's first bit appears on `sdo` with `frame_start` in the cycle after the edge where the token holder is taken. Its remaining twelve bits follow on the next twelve cycles. `ro_done` appears one cycle after the token leaves the last pixel, which for an empty matrix is 256 edges after the `tok_start` edge.

The bench's reference model steps once per rising edge, using the inputs that were set up at the previous falling edge. The model state is compared with the outputs at the next falling edge. Explicit checks on the empty-matrix readout count exact cycle numbers against these latencies.

// File: rtl/pixmat_pkg.sv
package pixmat_pkg;
   // Index width for a count of n items; never below one bit
   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pixmat_tscnt.sv
module pixmat_tscnt #(
   parameter int TSW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           detect,
   output logic [TSW-1:0] ts_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)      ts_cnt <= '0;
      else if (detect) ts_cnt <= ts_cnt + TSW'(1);
   end
endmodule

// File: rtl/pixmat_cell.sv
module pixmat_cell #(
   parameter int TSW   = 5,
   parameter bit FIRST = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           detect,
   input  logic           run,
   input  logic           inject,
   input  logic           ready,
   input  logic           hit_in,
   input  logic [TSW-1:0] ts_bus,
   input  logic           tok_in,
   output logic           hit_q,
   output logic           tok_q,
   output logic [TSW-1:0] ts_q,
   output logic           pass,
   output logic           grab
);
   // token leaves when the cell is empty or its frame is being taken
   assign grab = run & tok_q & hit_q & ready;
   assign pass = run & tok_q & (~hit_q | ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         ts_q  <= '0;
         tok_q <= 1'b0;
      end else begin
         if (detect && hit_in && !hit_q) hit_q <= 1'b1;
         else if (grab)                  hit_q <= 1'b0;
         if (!hit_q) ts_q <= ts_bus;
         if (inject) tok_q <= FIRST;
         else        tok_q <= (tok_q & ~pass) | tok_in;
      end
   end
endmodule

// File: rtl/pixmat_serial.sv
module pixmat_serial #(
   parameter int COLS = 16,
   parameter int ROWS = 16,
   parameter int TSW  = 5,
   parameter int XW   = 4,
   parameter int YW   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [COLS-1:0]          get_x,
   input  logic [ROWS-1:0]          get_y,
   input  logic [COLS-1:0][TSW-1:0] col_ts,
   output logic                     ready,
   output logic                     sdo,
   output logic                     frame_start
);
   localparam int FW = XW + YW + TSW;
   localparam int CW = $clog2(FW + 1);

   logic [XW-1:0]  x_addr;
   logic [YW-1:0]  y_addr;
   logic [TSW-1:0] ts_sel;
   logic [CW-1:0]  left;
   logic [FW-1:0]  sr;
   logic           load;

   // select lines are one-hot, so OR-encoding gives the index
   always_comb begin
      x_addr = '0;
      ts_sel = '0;
      for (int c = 0; c < COLS; c++) begin
         if (get_x[c]) begin
            x_addr = x_addr | XW'(c);
            ts_sel = ts_sel | col_ts[c];
         end
      end
   end

   always_comb begin
      y_addr = '0;
      for (int r = 0; r < ROWS; r++)
         if (get_y[r]) y_addr = y_addr | YW'(r);
   end

   assign load        = |get_x;
   assign ready       = (left <= CW'(1));
   assign sdo         = (left != '0) & sr[FW-1];
   assign frame_start = (left == CW'(FW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
         sr   <= '0;
      end else if (load) begin
         sr   <= {x_addr, y_addr, ts_sel};
         left <= CW'(FW);
      end else if (left != '0) begin
         sr   <= {sr[FW-2:0], 1'b0};
         left <= left - CW'(1);
      end
   end
endmodule

// File: rtl/pixmat_tokro.sv
module pixmat_tokro #(
   parameter int COLS = 16,
   parameter int ROWS = 16,
   parameter int TSW  = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 detect,
   input  logic                 tok_start,
   input  logic [ROWS*COLS-1:0] hit_in,
   output logic                 sdo,
   output logic                 frame_start,
   output logic                 ro_done
);
   localparam int NPIX = ROWS * COLS;
   localparam int XW   = pixmat_pkg::idx_w(COLS);
   localparam int YW   = pixmat_pkg::idx_w(ROWS);

   if (COLS < 2 || ROWS < 2) begin : g_bad_dim
      $error("pixmat_tokro: matrix needs at least 2 columns and 2 rows");
   end
   if (TSW < 1 || TSW > 16) begin : g_bad_tsw
      $error("pixmat_tokro: stamp width out of range");
   end

   logic [TSW-1:0]             ts_cnt;
   logic [NPIX-1:0]            hit_vec, tok_vec, pass_vec, grab_vec, chain_in;
   logic [TSW-1:0]             cell_ts [NPIX];
   logic [COLS-1:0]            get_x;
   logic [ROWS-1:0]            get_y;
   logic [COLS-1:0][TSW-1:0]   col_ts;
   logic                       ready, run;

   assign run      = ~detect & ~tok_start;
   assign chain_in = {pass_vec[NPIX-2:0], 1'b0};

   pixmat_tscnt #(.TSW(TSW)) u_tscnt (
      .clk(clk), .rst_n(rst_n), .detect(detect), .ts_cnt(ts_cnt));

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int I = r * COLS + c;
         pixmat_cell #(.TSW(TSW), .FIRST(I == 0)) u_cell (
            .clk(clk), .rst_n(rst_n), .detect(detect), .run(run),
            .inject(tok_start), .ready(ready), .hit_in(hit_in[I]),
            .ts_bus(ts_cnt), .tok_in(chain_in[I]),
            .hit_q(hit_vec[I]), .tok_q(tok_vec[I]), .ts_q(cell_ts[I]),
            .pass(pass_vec[I]), .grab(grab_vec[I]));
      end
   end

   // shared column/row select buses and per-column stamp buffers
   always_comb begin
      get_x  = '0;
      get_y  = '0;
      col_ts = '0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            if (grab_vec[r*COLS+c]) begin
               get_x[c]  = 1'b1;
               get_y[r]  = 1'b1;
               col_ts[c] = col_ts[c] | cell_ts[r*COLS+c];
            end
         end
      end
   end

   pixmat_serial #(.COLS(COLS), .ROWS(ROWS), .TSW(TSW), .XW(XW), .YW(YW)) u_serial (
      .clk(clk), .rst_n(rst_n), .get_x(get_x), .get_y(get_y), .col_ts(col_ts),
      .ready(ready), .sdo(sdo), .frame_start(frame_start));

   always_ff @(posedge clk) begin
      if (!rst_n)                  ro_done <= 1'b0;
      else if (tok_start)          ro_done <= 1'b0;
      else if (pass_vec[NPIX-1])   ro_done <= 1'b1;
   end
endmodule

// File: rtl/pixmat_tokro_chk.sv
module pixmat_tokro_chk #(
   parameter int NPIX = 256,
   parameter int TSW  = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            detect,
   input logic            tok_start,
   input logic            frame_start,
   input logic            ro_done,
   input logic [NPIX-1:0] tok,
   input logic [NPIX-1:0] hit,
   input logic [NPIX-1:0] grab,
   input logic [TSW-1:0]  ts_cnt
);
   a_r2_ts_inc: assert property (@(posedge clk) disable iff (!rst_n)
      detect |=> ts_cnt == ($past(ts_cnt) + TSW'(1)));
   a_r2_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !detect |=> $stable(ts_cnt));
   a_r3_no_set_readout: assert property (@(posedge clk) disable iff (!rst_n)
      !detect |=> ((hit & ~$past(hit)) == '0));
   a_r5_one_token: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tok));
   a_r7_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   a_r8_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      (grab != '0) |=> ((hit & $past(grab)) == '0));
   a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ro_done && !tok_start) |=> ro_done);
endmodule

bind pixmat_tokro pixmat_tokro_chk #(.NPIX(ROWS*COLS), .TSW(TSW)) u_chk (
   .clk(clk), .rst_n(rst_n), .detect(detect), .tok_start(tok_start),
   .frame_start(frame_start), .ro_done(ro_done), .tok(tok_vec),
   .hit(hit_vec), .grab(grab_vec), .ts_cnt(ts_cnt));

// File: tb/test_pixmat_tokro.sv
`timescale 1ns/1ps
module test_pixmat_tokro;
   localparam int N = 256;
   logic clk = 1'b0, rst_n = 1'b0, detect = 1'b0, tok_start = 1'b0;
   logic [N-1:0] hit_in = '0;
   logic sdo, frame_start, ro_done;

   pixmat_tokro i_pixmat_tokro (.clk(clk), .rst_n(rst_n), .detect(detect),
      .tok_start(tok_start), .hit_in(hit_in), .sdo(sdo),
      .frame_start(frame_start), .ro_done(ro_done));

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   // behavioural reference
   int mcnt, mpos, mleft;
   bit mhit [N];
   int mts  [N];
   bit mdone;
   logic [12:0] msr;
   // frame capture
   logic [12:0] cur;
   int bitn = 0;
   logic [12:0] got_q[$], exp_q[$];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit rdy;
      if (!rst_n) begin
         mcnt = 0; mpos = -1; mleft = 0; mdone = 0; msr = '0;
         for (int i = 0; i < N; i++) begin mhit[i] = 0; mts[i] = 0; end
      end else begin
         rdy = (mleft <= 1);
         if (mleft > 0) begin mleft--; msr = msr << 1; end
         if (tok_start) begin
            mpos = 0; mdone = 0;
         end else if (!detect && mpos >= 0 && mpos < N) begin
            if (!mhit[mpos] || rdy) begin
               if (mhit[mpos]) begin
                  msr = {4'(mpos % 16), 4'(mpos / 16), 5'(mts[mpos])};
                  mleft = 13; mhit[mpos] = 0;
               end
               mpos++;
               if (mpos == N) mdone = 1;
            end
         end
         if (detect) begin
            for (int i = 0; i < N; i++)
               if (hit_in[i] && !mhit[i]) begin mhit[i] = 1; mts[i] = mcnt; end
            mcnt = (mcnt + 1) % 32;
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R7,R8 sdo", sdo, (mleft > 0) ? msr[12] : 1'b0);
      check("R7 frame_start", frame_start, (mleft == 13));
      check("R5,R9 ro_done", ro_done, mdone);
      if (frame_start) begin cur = {12'b0, sdo}; bitn = 1; end
      else if (bitn > 0) begin cur = {cur[11:0], sdo}; bitn++; end
      if (bitn == 13) begin got_q.push_back(cur); bitn = 0; end
   endtask

   task automatic snapshot();
      exp_q.delete();
      for (int i = 0; i < N; i++)
         if (mhit[i]) exp_q.push_back({4'(i % 16), 4'(i / 16), 5'(mts[i])});
   endtask

   task automatic start_readout();
      detect = 1'b0; hit_in = '0; got_q.delete(); snapshot();
      tok_start = 1'b1; tick(); tok_start = 1'b0;
      check("R5 done cleared by token start", ro_done, 0);
   endtask

   initial begin
      #(20ns * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) tick();
      check("R1 sdo", sdo, 0);
      check("R1 frame_start", frame_start, 0);
      check("R1 ro_done", ro_done, 0);
      rst_n = 1'b1;

      // detection: first-cell hit, adjacent pair, repeat hit, last cell, wrap
      detect = 1'b1;
      for (int k = 0; k < 40; k++) begin
         hit_in = '0;
         case (k)
            3:  hit_in[0] = 1'b1;
            5:  begin hit_in[1] = 1'b1; hit_in[2] = 1'b1; end
            7:  hit_in[0] = 1'b1;            // R4 repeat ignored
            10: hit_in[255] = 1'b1;
            36: hit_in[17] = 1'b1;           // R2 stamp after wrap
            default: ;
         endcase
         tick();
      end
      check("R4 expected hit count", exp_q.size() + 0, 0);
      start_readout();
      check("R4,R6 hits pending", exp_q.size(), 5);
      hit_in[50] = 1'b1;                     // R3 ignored in readout
      for (int k = 0; k < 400 && !ro_done; k++) tick();
      hit_in = '0;
      repeat (20) tick();
      check("R9 done after readout", ro_done, 1);
      check("R3,R4,R8 frame count", got_q.size(), 5);
      for (int i = 0; i < 5 && i < got_q.size(); i++)
         check("R6,R7 frame content", got_q[i], exp_q[i]);

      // R9: empty matrix, exact latency
      start_readout();
      repeat (255) tick();
      check("R9 done not before 256 clocks", ro_done, 0);
      tick();
      check("R9 done at 256 clocks", ro_done, 1);
      repeat (15) tick();
      check("R9 no frames when empty", got_q.size(), 0);

      // R10: reset in mid detection discards hits
      detect = 1'b1;
      for (int k = 0; k < 10; k++) begin
         hit_in = '0;
         if (k == 2) begin hit_in[5] = 1'b1; hit_in[200] = 1'b1; end
         tick();
      end
      hit_in = '0; rst_n = 1'b0; tick(); rst_n = 1'b1;
      check("R1 done low after reset", ro_done, 0);
      for (int k = 0; k < 4; k++) begin
         hit_in = '0;
         if (k == 1) hit_in[9] = 1'b1;     // R2 stamp restarts from 0
         tick();
      end
      start_readout();
      for (int k = 0; k < 320 && !ro_done; k++) tick();
      repeat (15) tick();
      check("R10 only post-reset hit reported", got_q.size(), 1);
      if (got_q.size() > 0)
         check("R2,R10 stamp after reset", got_q[0], {4'd9, 4'd0, 5'd1});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule